// File: doc/BRIEF.md
# Matrix Keypad Status Controller

This block keeps the held-down state of an 8x8 key matrix and presents it to software as a small file of 32-bit registers, along with one interrupt line. Key activity arrives on a byte-wide event port as scan codes with a one-cycle valid strobe. Each code is translated into a row and column position. The block then updates a per-key bitmap, a running count of held keys, and a summary word. When exactly one key is held, the summary word names that key.

Software controls the block through a control word. That word holds the matrix enable, the interrupt enable, the scan-on-activity bit, a self-clearing scan request and two sticky interrupt flags. Reading the control word clears both flags and drops the interrupt line. Several further registers exist only as storage for neighbouring functions: direct keys, rotary position, raw matrix and debounce interval. Two of them lose their status flags when they are read. The physical scanning of the matrix and the debounce timing are handled outside this block.

Top module: `kpad_matrix_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every register reads zero and irq is low.
- R2: Registers sit at these byte offsets: control 0x00, direct 0x08, rotary 0x10, raw matrix 0x18, scan summary 0x20, key maps 0x28/0x30/0x38/0x40, debounce 0x48. A read at any other offset returns zero, and a write there changes nothing. Read data appears on reg_rdata one clock after reg_rd.
- R3: The key at row r, column c is held in key map word c/2 (offset 0x28 + 8*(c/2)), at bit r + 16*(c mod 2).
- R4: The table index is formed from the code in two steps. Bit 7 of the input code is taken as the release flag and replaced by the extended flag. Index bits 6:0 in the range 0x10..0x4F give k = index[6:0] - 0x10. When index bit 7 is 0, the key is row k[5:3], column k[2:0]. When index bit 7 is 1, the key is row k[2:0], column k[5:3]. Any other index maps to no key, and the event is ignored.
- R5: The code 0xE0 only sets the extended flag and has no other visible effect. The next non-prefix code that is consumed while the matrix is enabled clears the flag.
- R6: Key events are ignored while control bit 12 (matrix enable) is 0.
- R7: A press of a clear key sets its bit and increments the count. A release of a set key clears its bit and decrements the count. A press of a set key, or a release of a clear key, changes no bit and raises no interrupt.
- R8: After each accepted event, the scan summary is rebuilt. Bits 30:26 carry the count modulo 32 and all other bits are zero, except bits 7:0. If the count is not 1, bits 7:0 read 0xFF. If the count is 1, bits 7:4 hold the row and bits 3:0 hold the column of the held key.
- R9: When a release leaves a count of 1, the remaining key is found by searching the key map words in order 0 to 3. Within each word, bits 0..7 (even column) are searched before bits 16..23 (odd column), rows ascending. The first set bit wins.
- R10: An event raises the interrupt only when three conditions hold: it changed a key bit, control bit 30 or bit 29 is set, and control bit 11 is set. Raising the interrupt sets control bit 22 and drives irq high on the next clock.
- R11: A read of the control word returns its value. It then clears control bits 22 and 5 and drives irq low.
- R12: A control write stores the written value with bit 30 forced to 0.
- R13: Reading the rotary register clears its bits 31, 30, 15 and 14. Reading the raw matrix register clears its bit 31.
- R14: If an accepted key event and a software write to a key map or the scan summary fall in the same cycle, the event is applied and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_valid | input | 1 | Key code strobe, one cycle per code |
| ev_code | input | 8 | Key scan code; bit 7 marks a release |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Matrix interrupt, level |

## Verification
A wrong bitmap bit or a wrong count is not visible at the pins right away. It shows up later, in the key map words and in the count field of the scan summary, the next time software reads them. A wrong count can also stay hidden until a release brings the count down to one. At that moment the search order decides which row and column appear in the summary, so the bench holds keys in more than one map word and places extra bits by software writes. A stuck extended flag or a missed interrupt-gating term shows up one clock after the event, as a bit in the wrong map word or as a wrong irq level.

// File: rtl/kpad_pkg.sv
// Package: shared constants, register offsets and code-to-key mapping
// for the matrix keypad status controller. Assumes an 8x8 matrix packed
// two columns per 32-bit map word.
package kpad_pkg;

    localparam int NUM_ROWS   = 8;
    localparam int NUM_COLS   = 8;
    localparam int ROW_W      = $clog2(NUM_ROWS);
    localparam int COL_W      = $clog2(NUM_COLS);
    localparam int NUM_WORDS  = NUM_COLS / 2;
    localparam int HALF_SHIFT = 16;

    localparam logic [7:0] CODE_PREFIX = 8'hE0;
    localparam int         CODE_BASE   = 'h10;
    localparam int         CODE_SPAN   = NUM_ROWS * NUM_COLS;

    // register byte offsets
    localparam int OFS_CTL    = 'h00;
    localparam int OFS_DIRECT = 'h08;
    localparam int OFS_ROT    = 'h10;
    localparam int OFS_RAWMX  = 'h18;
    localparam int OFS_SCAN   = 'h20;
    localparam int OFS_MAP0   = 'h28;
    localparam int MAP_STRIDE = 'h08;
    localparam int OFS_DEB    = 'h48;

    // control word bit positions
    localparam int CTL_SCAN_REQ = 30;
    localparam int CTL_ACT_SCAN = 29;
    localparam int CTL_MFLAG    = 22;
    localparam int CTL_MEN      = 12;
    localparam int CTL_MIE      = 11;
    localparam int CTL_DFLAG    = 5;

    // scan summary layout
    localparam int SCAN_CNT_LSB = 26;
    localparam int SCAN_CNT_W   = 5;

    typedef struct packed {
        logic             ok;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } key_pos_t;

    // Translate an 8-bit table index into a matrix position.
    function automatic key_pos_t map_code(input logic [7:0] idx);
        key_pos_t   p;
        logic [6:0] k;
        k     = idx[6:0] - 7'(CODE_BASE);
        p.ok  = (int'(idx[6:0]) >= CODE_BASE) && (int'(idx[6:0]) < CODE_BASE + CODE_SPAN);
        if (idx[7]) begin
            p.row = k[2:0];
            p.col = k[5:3];
        end else begin
            p.row = k[5:3];
            p.col = k[2:0];
        end
        return p;
    endfunction

endpackage

// File: rtl/kpad_code_decoder.sv
// Code decoder: consumes key codes, tracks the extended-code prefix and
// emits an accepted press/release with its row and column. Assumes one
// code per ev_valid cycle; events are dropped while the matrix is off.
module kpad_code_decoder
    import kpad_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic [7:0]       ev_code,
    input  logic             matrix_en,
    output logic             acc_valid,
    output logic             acc_release,
    output logic [ROW_W-1:0] acc_row,
    output logic [COL_W-1:0] acc_col
);

    logic     ext_q;
    logic     is_prefix;
    logic     consume;
    key_pos_t pos;

    // Classify the incoming code and look up its position.
    always_comb begin
        is_prefix   = (ev_code == CODE_PREFIX);
        consume     = ev_valid && !is_prefix && matrix_en;
        pos         = map_code({ext_q, ev_code[6:0]});
        acc_valid   = consume && pos.ok;
        acc_release = ev_code[7];
        acc_row     = pos.row;
        acc_col     = pos.col;
    end

    // Extended flag: set by the prefix, cleared by the next consumed code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ext_q <= 1'b0;
        else if (ev_valid && is_prefix)
            ext_q <= 1'b1;
        else if (consume)
            ext_q <= 1'b0;
    end

endmodule

// File: rtl/kpad_key_tracker.sv
// Key tracker: holds the packed key map words, the held-key count and
// the scan summary. Accepted events take priority over software writes
// to the map words and the summary in the same cycle.
module kpad_key_tracker
    import kpad_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             acc_valid,
    input  logic                             acc_release,
    input  logic [ROW_W-1:0]                 acc_row,
    input  logic [COL_W-1:0]                 acc_col,
    input  logic [NUM_WORDS-1:0]             sw_wr_map,
    input  logic                             sw_wr_scan,
    input  logic [DATA_W-1:0]                sw_wdata,
    output logic [NUM_WORDS-1:0][DATA_W-1:0] map_words,
    output logic [DATA_W-1:0]                scan_q,
    output logic                             key_changed
);

    localparam int CNT_W  = $clog2(NUM_ROWS * NUM_COLS + 1);
    localparam int BIT_W  = $clog2(DATA_W);
    localparam int WSEL_W = $clog2(NUM_WORDS);

    logic [NUM_WORDS-1:0][DATA_W-1:0] map_nxt;
    logic [WSEL_W-1:0] wsel;
    logic [BIT_W-1:0]  bit_idx;
    logic              cur_set;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nxt;
    logic [ROW_W-1:0]  found_row;
    logic [COL_W-1:0]  found_col;
    logic [7:0]        rowcol;
    logic [DATA_W-1:0] scan_nxt;

    // Locate the event's bit and decide whether it changes state.
    always_comb begin
        wsel        = acc_col[COL_W-1:1];
        bit_idx     = BIT_W'(acc_row) + (acc_col[0] ? BIT_W'(HALF_SHIFT) : '0);
        cur_set     = map_words[wsel][bit_idx];
        key_changed = acc_valid && (acc_release ? cur_set : !cur_set);
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [DATA_W-1:0] word_q;
        logic [DATA_W-1:0] word_nxt;

        // Next value of one map word: event first, else software write.
        always_comb begin
            word_nxt = word_q;
            if (acc_valid) begin
                if (key_changed && (wsel == WSEL_W'(w)))
                    word_nxt[bit_idx] = !word_q[bit_idx];
            end else if (sw_wr_map[w]) begin
                word_nxt = sw_wdata;
            end
        end

        // Map word storage.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else
                word_q <= word_nxt;
        end

        assign map_words[w] = word_q;
        assign map_nxt[w]   = word_nxt;
    end

    // Held-key count follows each state-changing event.
    always_comb begin
        cnt_nxt = cnt_q;
        if (key_changed)
            cnt_nxt = acc_release ? cnt_q - CNT_W'(1) : cnt_q + CNT_W'(1);
    end

    // Fixed-order search for the first held key in the updated map.
    always_comb begin
        found_row = '0;
        found_col = '0;
        for (int c = NUM_COLS - 1; c >= 0; c--) begin
            for (int r = NUM_ROWS - 1; r >= 0; r--) begin
                if (map_nxt[c / 2][r + HALF_SHIFT * (c % 2)]) begin
                    found_row = ROW_W'(r);
                    found_col = COL_W'(c);
                end
            end
        end
    end

    // Rebuild the scan summary for an accepted event.
    always_comb begin
        if (cnt_nxt != CNT_W'(1))
            rowcol = 8'hFF;
        else if (acc_release)
            rowcol = {1'b0, found_row, 1'b0, found_col};
        else
            rowcol = {1'b0, acc_row, 1'b0, acc_col};
        scan_nxt = '0;
        scan_nxt[SCAN_CNT_LSB +: SCAN_CNT_W] = cnt_nxt[SCAN_CNT_W-1:0];
        scan_nxt[7:0] = rowcol;
    end

    // Count and summary storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            scan_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            if (acc_valid)
                scan_q <= scan_nxt;
            else if (sw_wr_scan)
                scan_q <= sw_wdata;
        end
    end

endmodule

// File: rtl/kpad_reg_bank.sv
// Register bank: address decode, control word with sticky flags, plain
// storage registers with clear-on-read flags, registered read data and
// the interrupt line. Assumes at most one of read or write per offset.
module kpad_reg_bank
    import kpad_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_wr,
    input  logic                             reg_rd,
    input  logic [ADDR_W-1:0]                reg_addr,
    input  logic [DATA_W-1:0]                reg_wdata,
    input  logic                             key_changed,
    input  logic [NUM_WORDS-1:0][DATA_W-1:0] map_words,
    input  logic [DATA_W-1:0]                scan_q,
    output logic [NUM_WORDS-1:0]             sw_wr_map,
    output logic                             sw_wr_scan,
    output logic                             matrix_en,
    output logic [DATA_W-1:0]                reg_rdata,
    output logic                             irq
);

    logic [DATA_W-1:0] ctl_q, ctl_nxt;
    logic [DATA_W-1:0] direct_q, rot_q, rot_nxt, rawmx_q, rawmx_nxt, deb_q;
    logic [DATA_W-1:0] rd_val;
    logic              rd_ctl, wr_ctl, rd_rot, rd_rawmx, irq_set;

    // Offset decode for the storage registers.
    always_comb begin
        rd_ctl     = reg_rd && (reg_addr == ADDR_W'(OFS_CTL));
        wr_ctl     = reg_wr && (reg_addr == ADDR_W'(OFS_CTL));
        rd_rot     = reg_rd && (reg_addr == ADDR_W'(OFS_ROT));
        rd_rawmx   = reg_rd && (reg_addr == ADDR_W'(OFS_RAWMX));
        sw_wr_scan = reg_wr && (reg_addr == ADDR_W'(OFS_SCAN));
    end

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_map_wr
        assign sw_wr_map[i] = reg_wr && (reg_addr == ADDR_W'(OFS_MAP0 + MAP_STRIDE * i));
    end

    assign matrix_en = ctl_q[CTL_MEN];

    // Interrupt qualification for a state-changing event.
    always_comb begin
        irq_set = key_changed
               && (ctl_q[CTL_SCAN_REQ] || ctl_q[CTL_ACT_SCAN])
               && ctl_q[CTL_MIE];
    end

    // Control word: read clears flags, write drops scan request, event sets flag.
    always_comb begin
        ctl_nxt = ctl_q;
        if (rd_ctl) begin
            ctl_nxt[CTL_MFLAG] = 1'b0;
            ctl_nxt[CTL_DFLAG] = 1'b0;
        end
        if (wr_ctl) begin
            ctl_nxt = reg_wdata;
            ctl_nxt[CTL_SCAN_REQ] = 1'b0;
        end
        if (irq_set)
            ctl_nxt[CTL_MFLAG] = 1'b1;
    end

    // Clear-on-read flags of the rotary and raw matrix registers.
    always_comb begin
        rot_nxt = rot_q;
        if (rd_rot) begin
            rot_nxt[31] = 1'b0;
            rot_nxt[30] = 1'b0;
            rot_nxt[15] = 1'b0;
            rot_nxt[14] = 1'b0;
        end
        if (reg_wr && (reg_addr == ADDR_W'(OFS_ROT)))
            rot_nxt = reg_wdata;
        rawmx_nxt = rawmx_q;
        if (rd_rawmx)
            rawmx_nxt[31] = 1'b0;
        if (reg_wr && (reg_addr == ADDR_W'(OFS_RAWMX)))
            rawmx_nxt = reg_wdata;
    end

    // Read multiplexer; unknown offsets return zero.
    always_comb begin
        rd_val = '0;
        case (reg_addr)
            ADDR_W'(OFS_CTL):    rd_val = ctl_q;
            ADDR_W'(OFS_DIRECT): rd_val = direct_q;
            ADDR_W'(OFS_ROT):    rd_val = rot_q;
            ADDR_W'(OFS_RAWMX):  rd_val = rawmx_q;
            ADDR_W'(OFS_SCAN):   rd_val = scan_q;
            ADDR_W'(OFS_DEB):    rd_val = deb_q;
            default:             rd_val = '0;
        endcase
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (reg_addr == ADDR_W'(OFS_MAP0 + MAP_STRIDE * i))
                rd_val = map_words[i];
        end
    end

    // Register storage, read data and interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            direct_q  <= '0;
            rot_q     <= '0;
            rawmx_q   <= '0;
            deb_q     <= '0;
            reg_rdata <= '0;
            irq       <= 1'b0;
        end else begin
            ctl_q   <= ctl_nxt;
            rot_q   <= rot_nxt;
            rawmx_q <= rawmx_nxt;
            if (reg_wr && (reg_addr == ADDR_W'(OFS_DIRECT)))
                direct_q <= reg_wdata;
            if (reg_wr && (reg_addr == ADDR_W'(OFS_DEB)))
                deb_q <= reg_wdata;
            if (reg_rd)
                reg_rdata <= rd_val;
            if (irq_set)
                irq <= 1'b1;
            else if (rd_ctl)
                irq <= 1'b0;
        end
    end

endmodule

// File: rtl/kpad_matrix_ctrl.sv
// Top level of the matrix keypad status controller: joins the code
// decoder, the key tracker and the register bank. Assumes a single
// clock domain and codes already debounced upstream.
module kpad_matrix_ctrl
    import kpad_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [7:0]        ev_code,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    logic                             matrix_en;
    logic                             acc_valid;
    logic                             acc_release;
    logic [ROW_W-1:0]                 acc_row;
    logic [COL_W-1:0]                 acc_col;
    logic [NUM_WORDS-1:0]             sw_wr_map;
    logic                             sw_wr_scan;
    logic [NUM_WORDS-1:0][DATA_W-1:0] map_words;
    logic [DATA_W-1:0]                scan_q;
    logic                             key_changed;

    kpad_code_decoder u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_valid    (ev_valid),
        .ev_code     (ev_code),
        .matrix_en   (matrix_en),
        .acc_valid   (acc_valid),
        .acc_release (acc_release),
        .acc_row     (acc_row),
        .acc_col     (acc_col)
    );

    kpad_key_tracker #(.DATA_W(DATA_W)) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_release (acc_release),
        .acc_row     (acc_row),
        .acc_col     (acc_col),
        .sw_wr_map   (sw_wr_map),
        .sw_wr_scan  (sw_wr_scan),
        .sw_wdata    (reg_wdata),
        .map_words   (map_words),
        .scan_q      (scan_q),
        .key_changed (key_changed)
    );

    kpad_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .key_changed (key_changed),
        .map_words   (map_words),
        .scan_q      (scan_q),
        .sw_wr_map   (sw_wr_map),
        .sw_wr_scan  (sw_wr_scan),
        .matrix_en   (matrix_en),
        .reg_rdata   (reg_rdata),
        .irq         (irq)
    );

endmodule

// File: rtl/kpad_matrix_ctrl_chk.sv
// Checker: temporal properties of the keypad controller, attached to
// the top module by bind. Observes ports and inter-module signals only.
module kpad_matrix_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         ev_valid,
    input logic                         reg_wr,
    input logic                         reg_rd,
    input logic [ADDR_W-1:0]            reg_addr,
    input logic                         irq,
    input logic                         matrix_en,
    input logic                         acc_valid,
    input logic                         key_changed,
    input logic [WORDS-1:0][DATA_W-1:0] map_words,
    input logic [DATA_W-1:0]            scan_q
);

    // R10
    irq_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(key_changed));

    // R11
    ctl_read_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(0) && !key_changed) |=> !irq);

    // R6
    disabled_event_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !matrix_en && !reg_wr) |=> ($stable(map_words) && $stable(scan_q)));

    // R8
    summary_idle_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acc_valid) && scan_q[30:26] != 5'd1) |-> scan_q[7:0] == 8'hFF);

    // R7
    change_moves_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_changed |=> map_words != $past(map_words));

endmodule

bind kpad_matrix_ctrl kpad_matrix_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .WORDS (kpad_pkg::NUM_WORDS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_valid    (ev_valid),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .irq         (irq),
    .matrix_en   (matrix_en),
    .acc_valid   (acc_valid),
    .key_changed (key_changed),
    .map_words   (map_words),
    .scan_q      (scan_q)
);

// File: tb/kpad_matrix_ctrl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected read data, a monitor
// pops and compares each registered read result.
module kpad_matrix_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [7:0]  ev_code = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int          n_checks = 0;
    int          n_fail = 0;
    bit          rd_seen = 1'b0;
    bit          finished = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [31:0] CTL_RUN = 32'h2000_1800;
    localparam logic [31:0] CTL_HIT = 32'h2040_1800;

    always #10 clk = ~clk;

    kpad_matrix_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid  (ev_valid),
        .ev_code   (ev_code),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] kcode(input int row, input int col);
        return 8'(16 + row * 8 + col);
    endfunction

    task automatic rd(input logic [7:0] addr, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_rd = 1'b1;
        reg_addr = addr;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = addr;
        reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic key(input logic [7:0] code);
        @(negedge clk);
        ev_valid = 1'b1;
        ev_code = code;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        check(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Note which cycles carried a read.
    always @(posedge clk) rd_seen <= reg_rd;

    // Monitor: compare each registered read result against the queue.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL scoreboard unexpected read actual %h expected none", reg_rdata);
            end else begin
                check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual running expected done");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_irq(1'b0, "R1 irq");
        rd(8'h00, 32'h0, "R1 ctl");
        rd(8'h08, 32'h0, "R1 direct");
        rd(8'h10, 32'h0, "R1 rotary");
        rd(8'h18, 32'h0, "R1 raw");
        rd(8'h20, 32'h0, "R1 scan");
        for (int i = 0; i < 4; i++) rd(8'(40 + 8 * i), 32'h0, "R1 map");
        rd(8'h48, 32'h0, "R1 debounce");

        // R2 unknown offsets
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, 32'h0, "R2 hole read");
        rd(8'h50, 32'h0, "R2 past end");
        rd(8'h08, 32'h0, "R2 no alias");

        // R12 then R11 on the control word
        wr(8'h00, 32'h4040_1020);
        rd(8'h00, 32'h0040_1020, "R12 scan request dropped");
        rd(8'h00, 32'h0000_1000, "R11 flags cleared");

        // R6 matrix disabled
        wr(8'h00, 32'h2000_0800);
        key(kcode(2, 3));
        chk_irq(1'b0, "R6 irq");
        rd(8'h30, 32'h0, "R6 map");
        rd(8'h20, 32'h0, "R6 scan");

        // R3 R8 R10 first press
        wr(8'h00, CTL_RUN);
        key(kcode(2, 3));
        chk_irq(1'b1, "R10 irq raised");
        rd(8'h30, 32'h0004_0000, "R3 odd column bit");
        rd(8'h20, 32'h0400_0023, "R8 single key");
        rd(8'h00, CTL_HIT, "R11 flag seen");
        chk_irq(1'b0, "R11 irq dropped");

        // R7 duplicate press
        key(kcode(2, 3));
        chk_irq(1'b0, "R7 duplicate irq");
        rd(8'h20, 32'h0400_0023, "R7 duplicate summary");

        // R8 two keys
        key(kcode(5, 0));
        chk_irq(1'b1, "R10 second press");
        rd(8'h28, 32'h0000_0020, "R3 even column bit");
        rd(8'h20, 32'h0800_00FF, "R8 two keys");
        rd(8'h00, CTL_HIT, "R11 clear");

        // R9 release leaves one
        key(8'h80 | kcode(2, 3));
        rd(8'h30, 32'h0, "R7 release clears");
        rd(8'h20, 32'h0400_0050, "R9 remaining key");
        rd(8'h00, CTL_HIT, "R10 release irq flag");

        // R9 order: even before odd, lower word before higher
        key(kcode(3, 7));
        rd(8'h00, CTL_HIT, "R11 clear");
        wr(8'h30, 32'h0001_0040);
        key(8'h80 | kcode(5, 0));
        rd(8'h20, 32'h0400_0062, "R9 search order");
        rd(8'h00, CTL_HIT, "R11 clear");
        key(8'h80 | kcode(5, 0));
        chk_irq(1'b0, "R7 release of clear key");

        // R5 prefix, R4 extended and plain decoding
        key(8'hE0);
        chk_irq(1'b0, "R5 prefix irq");
        rd(8'h40, 32'h0008_0000, "R5 prefix alone");
        key(8'h44);
        rd(8'h40, 32'h0008_0010, "R4 extended swap");
        rd(8'h20, 32'h0800_00FF, "R8 count two");
        rd(8'h00, CTL_HIT, "R11 clear");
        key(8'h44);
        rd(8'h38, 32'h0000_0040, "R4 plain after prefix");
        rd(8'h00, CTL_HIT, "R11 clear");
        key(8'h05);
        chk_irq(1'b0, "R4 unmapped irq");
        rd(8'h20, 32'h0C00_00FF, "R4 unmapped summary");

        // R14 event beats same-cycle map write
        @(negedge clk);
        ev_valid = 1'b1;
        ev_code = kcode(0, 0);
        reg_wr = 1'b1;
        reg_addr = 8'h28;
        reg_wdata = 32'h0000_FFFF;
        @(negedge clk);
        ev_valid = 1'b0;
        reg_wr = 1'b0;
        rd(8'h28, 32'h0000_0001, "R14 event priority");
        rd(8'h20, 32'h1000_00FF, "R14 count four");
        rd(8'h00, CTL_HIT, "R11 clear");

        // R13 clear-on-read, R2 plain storage
        wr(8'h10, 32'hC000_C0FF);
        rd(8'h10, 32'hC000_C0FF, "R13 rotary first");
        rd(8'h10, 32'h0000_00FF, "R13 rotary cleared");
        wr(8'h18, 32'h8000_0012);
        rd(8'h18, 32'h8000_0012, "R13 raw first");
        rd(8'h18, 32'h0000_0012, "R13 raw cleared");
        wr(8'h48, 32'h0000_1234);
        rd(8'h48, 32'h0000_1234, "R2 debounce storage");
        wr(8'h08, 32'h0000_00A5);
        rd(8'h08, 32'h0000_00A5, "R2 direct storage");

        // R10 gating terms
        wr(8'h00, 32'h0000_1800);
        key(kcode(7, 7));
        chk_irq(1'b0, "R10 no activity bit");
        rd(8'h40, 32'h0088_0010, "R10 map still updates");
        rd(8'h00, 32'h0000_1800, "R10 flag stays clear");
        wr(8'h00, 32'h2000_1000);
        key(8'h80 | kcode(7, 7));
        chk_irq(1'b0, "R10 no enable bit");
        rd(8'h40, 32'h0008_0010, "R7 release restores");
        rd(8'h00, 32'h2000_1000, "R10 flag stays clear");

        repeat (3) @(negedge clk);
        summary();
    end

endmodule